// File: doc/BRIEF.md
# PCI Power-State Handshake Controller

This block carries a power-management handshake between an external PCI host and the local processor of the device. The host writes the device power state it wants through a small host-side register port. The local processor sees that wish as a read-only request field in one 32-bit status word. Whenever the wish differs from the state the processor last confirmed, the block raises an interrupt.

The processor confirms a transition by writing a current-state field in the same word. It writes it once just before it enters a requested low-power state, and again once the device is back in full power. The confirmed value is mirrored into the host-visible power-state register, so the host learns that the device has arrived. The interrupt is a level. It clears by itself once the confirmed state matches the request, and it needs no acknowledge.

Power states are coded on two bits: 00 is D0 (full power), 01 is D1, 10 is D2, and 11 is D3. The hot and warm variants of D3 share code 11.

Top module: `pwrhs_ctrl`

## Requirements
- R1: After reset, the request field and the current-state field are both 00 (D0), irq_o is low and host_rdata_o reads 00.
- R2: A host write (host_wr_en_i high at a rising edge) stores host_wdata_i as the request field, which appears in loc_rdata_o bits [3:2] (LSB-0 numbering) right after that edge.
- R3: All four codes (00 = D0, 01 = D1, 10 = D2, 11 = D3, with D3hot and D3warm both 11) are stored and returned unchanged in both fields.
- R4: irq_o is a level that is high in the cycle after any edge at which the stored request and current-state fields differ, and stays high while they differ.
- R5: irq_o falls, with no acknowledge, one edge after the edge at which the stored fields become equal.
- R6: A local write (loc_wr_en_i high at a rising edge) stores loc_wdata_i bits [1:0] as the current-state field. host_rdata_o returns that value right after the edge and never returns a pending request.
- R7: Local writes leave the request field unchanged, whatever loc_wdata_i bits [3:2] and [31:4] hold.
- R8: loc_rdata_o holds the request field at bits [3:2] and the current-state field at bits [1:0], and reads zero in bits [31:4].
- R9: A host write and a local write at the same edge both take effect, and the interrupt at the next edge is computed from the two updated fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr_en_i | input | 1 | Host write strobe for the requested power state |
| host_wdata_i | input | 2 | Requested power-state code from the host |
| host_rdata_o | output | 2 | Host-visible power state, mirrored from the current-state field |
| loc_wr_en_i | input | 1 | Local processor write strobe for the status word |
| loc_wdata_i | input | 32 | Local write data; only bits [1:0] are used |
| loc_rdata_o | output | 32 | Local status word: request at [3:2], current state at [1:0] |
| irq_o | output | 1 | Level interrupt to the local processor while the two fields differ |

## Verification
The bench targets the edges of the mirrored handshake. It checks the one-edge lag of the interrupt behind the fields, and that the interrupt clears on its own once the confirmed state matches. A design that compared the old values, or that waited for an acknowledge, would leave irq_o high one cycle too long or forever. Local writes carry ones in the request bits and the unused bits: a design that let those through would corrupt the request or show set upper bits in the status word. Host and local writes that land together, with equal and with unequal codes, catch a design that drops one of the two writes or builds the interrupt from stale values.

// File: rtl/pwrhs_pkg.sv
package pwrhs_pkg;
  localparam int unsigned PS_W = 2;

  typedef enum logic [PS_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/pwrhs_rst_sync.sv
module pwrhs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwrhs_state_reg.sv
module pwrhs_state_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] state_q
);
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) state_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state_q == $past(wdata)));
endmodule

// File: rtl/pwrhs_irq_gen.sv
module pwrhs_irq_gen #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] cur,
  output logic         irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = (req != cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/pwrhs_rd_mux.sv
module pwrhs_rd_mux #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned W       = 2,
  parameter int unsigned REQ_LSB = 2,
  parameter int unsigned CUR_LSB = 0
) (
  input  logic [W-1:0]      req,
  input  logic [W-1:0]      cur,
  output logic [DATA_W-1:0] rdata
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= REQ_LSB && b < REQ_LSB + W) begin : g_req
      assign rdata[b] = req[b - REQ_LSB];
    end else if (b >= CUR_LSB && b < CUR_LSB + W) begin : g_cur
      assign rdata[b] = cur[b - CUR_LSB];
    end else begin : g_zero
      assign rdata[b] = 1'b0;
    end
  end
endmodule

// File: rtl/pwrhs_ctrl.sv
module pwrhs_ctrl #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REQ_LSB = 2,
  parameter int unsigned CUR_LSB = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr_en_i,
  input  logic [pwrhs_pkg::PS_W-1:0] host_wdata_i,
  output logic [pwrhs_pkg::PS_W-1:0] host_rdata_o,
  input  logic                       loc_wr_en_i,
  input  logic [DATA_W-1:0]          loc_wdata_i,
  output logic [DATA_W-1:0]          loc_rdata_o,
  output logic                       irq_o
);
  import pwrhs_pkg::*;

  localparam int unsigned W = PS_W;

  logic         rst_sync_n;
  logic [W-1:0] req_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] loc_cur_wdata;
  logic         unused_loc_wbits;

  assign loc_cur_wdata    = loc_wdata_i[CUR_LSB +: W];
  assign unused_loc_wbits = ^loc_wdata_i;

  pwrhs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Request field: written only from the host side.
  pwrhs_state_reg #(.W(W)) u_req_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (host_wr_en_i),
    .wdata   (host_wdata_i),
    .state_q (req_q)
  );

  // Current-state field: written only from the local side.
  pwrhs_state_reg #(.W(W)) u_cur_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (loc_wr_en_i),
    .wdata   (loc_cur_wdata),
    .state_q (cur_q)
  );

  pwrhs_irq_gen #(.W(W)) u_irq_gen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (req_q),
    .cur   (cur_q),
    .irq_q (irq_o)
  );

  pwrhs_rd_mux #(
    .DATA_W  (DATA_W),
    .W       (W),
    .REQ_LSB (REQ_LSB),
    .CUR_LSB (CUR_LSB)
  ) u_rd_mux (
    .req   (req_q),
    .cur   (cur_q),
    .rdata (loc_rdata_o)
  );

  assign host_rdata_o = cur_q;

  // Assertions at the port level
  assert_host_mirror_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    loc_wr_en_i |=> (host_rdata_o == $past(loc_cur_wdata)));

  assert_req_untouched_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_wr_en_i |=> $stable(req_q));

  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (loc_rdata_o[REQ_LSB +: W] != host_rdata_o) |=> irq_o);

  assert_irq_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (loc_wr_en_i && !host_wr_en_i && (loc_cur_wdata == req_q)) |=> ##1 !irq_o);

  assert_dual_write_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr_en_i && loc_wr_en_i) |=>
      ((req_q == $past(host_wdata_i)) && (cur_q == $past(loc_cur_wdata))));
endmodule

// File: tb/pwrhs_ctrl_bench.sv
module pwrhs_ctrl_bench;
  localparam int unsigned DW = 32;

  logic          clk;
  logic          rst_n;
  logic          host_wr_en;
  logic [1:0]    host_wdata;
  logic [1:0]    host_rdata;
  logic          loc_wr_en;
  logic [DW-1:0] loc_wdata;
  logic [DW-1:0] loc_rdata;
  logic          irq;

  pwrhs_ctrl u_pwrhs_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en_i (host_wr_en),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata),
    .loc_wr_en_i  (loc_wr_en),
    .loc_wdata_i  (loc_wdata),
    .loc_rdata_o  (loc_rdata),
    .irq_o        (irq)
  );

  typedef struct {
    int            cyc;
    string         tag;
    logic          irq;
    logic [DW-1:0] lrd;
    logic [1:0]    hrd;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  // Reference model state
  logic [1:0] m_req = 2'b00;
  logic [1:0] m_cur = 2'b00;
  logic       m_irq = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops items due at this cycle and compares.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (irq !== e.irq || loc_rdata !== e.lrd || host_rdata !== e.hrd) begin
        n_errors++;
        $display("FAIL %s: actual irq=%b lrd=%h hrd=%b expected irq=%b lrd=%h hrd=%b",
                 e.tag, irq, loc_rdata, host_rdata, e.irq, e.lrd, e.hrd);
      end
    end
  end

  // Driver: call at a falling edge; applies inputs for one rising edge.
  task automatic step(input string tag, input bit hw, input logic [1:0] hd,
                      input bit lw, input logic [DW-1:0] ld);
    exp_t e;
    logic nirq;
    host_wr_en = hw;
    host_wdata = hd;
    loc_wr_en  = lw;
    loc_wdata  = ld;
    nirq = (m_req != m_cur);
    if (hw) m_req = hd;
    if (lw) m_cur = ld[1:0];
    m_irq = nirq;
    e.cyc = cyc + 1;
    e.tag = tag;
    e.irq = m_irq;
    e.lrd = {28'd0, m_req, m_cur};
    e.hrd = m_cur;
    exp_q.push_back(e);
    @(negedge clk);
    host_wr_en = 1'b0;
    loc_wr_en  = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 2'b00, 1'b0, '0);
  endtask

  initial begin
    rst_n = 1'b0;
    host_wr_en = 1'b0;
    host_wdata = 2'b00;
    loc_wr_en = 1'b0;
    loc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    idle("R1");
    // Walk through D1, D2, D3 requests with processor confirmation.
    for (int s = 1; s < 4; s++) begin
      step("R2", 1'b1, 2'(s), 1'b0, '0);
      idle("R4");
      idle("R4");
      step("R6", 1'b0, 2'b00, 1'b1, 32'(s));
      idle("R5");
    end
    // Return to D0 (R3 code 00)
    step("R3", 1'b1, 2'b00, 1'b0, '0);
    idle("R4");
    step("R6", 1'b0, 2'b00, 1'b1, 32'h0);
    idle("R5");
    // Local write with ones in request and unused bits
    step("R7", 1'b0, 2'b00, 1'b1, 32'hFFFF_FFFC);
    idle("R8");
    step("R7", 1'b0, 2'b00, 1'b1, 32'hFFFF_FFF2);
    idle("R8");
    idle("R5");
    // Simultaneous writes, equal codes
    step("R9", 1'b1, 2'b11, 1'b1, 32'h3);
    idle("R9");
    idle("R9");
    // Simultaneous writes, different codes
    step("R9", 1'b1, 2'b01, 1'b1, 32'h2);
    idle("R9");
    // Host changes request while already mismatched
    step("R4", 1'b1, 2'b10, 1'b0, '0);
    idle("R4");
    step("R5", 1'b0, 2'b00, 1'b1, 32'h2);
    idle("R5");
    idle("R1");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R1: actual %0d unchecked items expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_errors++;
      $display("FAIL R1: actual watchdog expired expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule